// File: doc/BRIEF.md
# Parallel ROM Read Controller with Word and Byte Lanes

This block sits between a synchronous host and an asynchronous parallel ROM whose data bus is either sixteen bits (word mode) or eight bits (byte mode). The host offers one read at a time with an address and a mode flag. The controller places the address, selects the bus width, enables the chip and its outputs, and holds them for a wait count. That count is derived at elaboration time from nanosecond timing parameters and the clock period, and is always rounded up. It then captures the lanes and returns a sixteen-bit result with a one-cycle valid pulse. Between reads the chip enable returns high so the ROM sits in standby.

In byte mode the ROM's top data pin stops being data and becomes the lowest address bit. The controller therefore owns a separate drive enable for that pin. It only turns the drive on while an access is running in byte mode. When a byte read follows a word read, it first waits for the ROM's output float time to pass after the output enable rose, so the two drivers never fight.

Request side: `req_ready` is high only while the controller is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. The host may hold `req_valid` high and must keep the address and mode stable until the request is taken. The response side has no back-pressure: `rsp_valid` is high for exactly one cycle, and the host must take `rsp_data` in that cycle. A new request may be offered in the same cycle as the response.

Top module: `prom_rd_ctrl`

## Requirements
- R1: After reset and whenever idle, `rom_ce_n` and `rom_oe_n` are 1, `rom_d15_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: `req_ready` is 0 from the cycle after a request is taken until the response cycle. A request held valid through an access is taken exactly once per idle window.
- R3: A word-mode read (`req_byte`=0) drives `rom_byte_n`=1 and `rom_addr`=`req_addr[22:0]`, with `req_addr[23]` having no effect. It returns all sixteen lanes unchanged in `rsp_data`.
- R4: A byte-mode read (`req_byte`=1) drives `rom_byte_n`=0, `rom_addr`=`req_addr[23:1]` and `rom_d15_out`=`req_addr[0]`. It returns `{8'h00, lanes[7:0]}`.
- R5: `rom_ce_n` and `rom_oe_n` stay low for exactly ACC_CYC cycles per read. ACC_CYC is the largest of the rounded-up address-access, output-enable-access and read-cycle times, expressed in clocks (10 at the defaults). The lanes are sampled at the end of that window.
- R6: `rsp_valid` is high for one cycle per taken request, in the first cycle after the enable window closes. With no turnaround, the request-to-response latency is ACC_CYC+1 cycles.
- R7: `rom_d15_oe` is 1 only while both enables are low in byte mode, for the whole of such an access, and never in word mode.
- R8: A byte read that follows a word read does not start, and does not drive the top lane, until at least HZ_CYC cycles (2 at the defaults) have passed with `rom_oe_n` high. `rom_ce_n` stays high during that wait.
- R9: A read that follows a byte read starts on the cycle after it is taken, with no turnaround wait.
- R10: `rom_addr`, `rom_byte_n` and `rom_d15_out` are stable for the whole enable window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | 24 | Byte address (byte mode) or word address in bits 22:0 (word mode) |
| req_byte | input | 1 | 1 = byte-mode read, 0 = word-mode read |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_data | output | 16 | Read result, zero-extended in byte mode |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_byte_n | output | 1 | ROM width select, 1 = word, 0 = byte |
| rom_addr | output | 23 | ROM address lines |
| rom_d_in | input | 16 | ROM data lanes as seen by the controller |
| rom_d15_out | output | 1 | Value driven on the top lane in byte mode |
| rom_d15_oe | output | 1 | Drive enable for the top lane |

## Verification
The response strobe and the taking of the next request can fall in the same cycle, because `req_ready` is already high while `rsp_valid` is. The bench provokes this by offering a byte read at the very cycle a word result appears. That read then also hits the turnaround wait against the word read just finished. It is judged by a latency one cycle longer than a plain read, by the count of idle cycles before the top lane is driven, and by a correct byte. The ROM model returns unknown data until its access times have passed, so any early sample would show up as a wrong result.

// File: rtl/prom_pkg.sv
package prom_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TURN = 2'd1,
    ST_ACC  = 2'd2
  } prom_st_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/prom_tick_cnt.sv
module prom_tick_cnt #(
  parameter int LIMIT   = 9,
  parameter bit SAT_RST = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic done
);
  localparam int W = $clog2(LIMIT + 2);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= SAT_RST ? LIM : '0;
    else if (clr)        cnt <= '0;
    else if (cnt < LIM)  cnt <= cnt + 1'b1;
  end

  assign done = (cnt >= LIM);
endmodule

// File: rtl/prom_lane_pick.sv
module prom_lane_pick #(
  parameter int DW = 16
) (
  input  logic          byte_mode,
  input  logic [DW-1:0] lanes,
  output logic [DW-1:0] value
);
  localparam int LW = DW / 2;

  always_comb begin
    if (byte_mode) value = {{(DW-LW){1'b0}}, lanes[LW-1:0]};
    else           value = lanes;
  end
endmodule

// File: rtl/prom_rd_ctrl.sv
module prom_rd_ctrl #(
  parameter int WA       = 23,
  parameter int DW       = 16,
  parameter int CLK_PS   = 10000,
  parameter int T_AA_PS  = 100000,
  parameter int T_OE_PS  = 30000,
  parameter int T_RC_PS  = 100000,
  parameter int T_HZ_PS  = 20000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [WA:0]   req_addr,
  input  logic          req_byte,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rom_ce_n,
  output logic          rom_oe_n,
  output logic          rom_byte_n,
  output logic [WA-1:0] rom_addr,
  input  logic [DW-1:0] rom_d_in,
  output logic          rom_d15_out,
  output logic          rom_d15_oe
);
  import prom_pkg::*;

  localparam int BW      = WA + 1;
  localparam int AA_CYC  = ceil_div(T_AA_PS, CLK_PS);
  localparam int OE_CYC  = ceil_div(T_OE_PS, CLK_PS);
  localparam int RC_CYC  = ceil_div(T_RC_PS, CLK_PS);
  localparam int ACC_CYC = max2(1, max2(AA_CYC, max2(OE_CYC, RC_CYC)));
  localparam int HZ_CYC  = max2(1, ceil_div(T_HZ_PS, CLK_PS));

  prom_st_e      st;
  logic [BW-1:0] addr_q;
  logic          mode_q;
  logic          prev_byte;
  logic          acc_done;
  logic          hz_ok;
  logic          accept;
  logic          need_turn;
  logic [DW-1:0] picked;

  // access window: cleared whenever the enables are high
  prom_tick_cnt #(.LIMIT(ACC_CYC - 1), .SAT_RST(1'b0)) u_acc_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (st != ST_ACC),
    .done  (acc_done)
  );

  // float timer: counts clocks with output enable high
  prom_tick_cnt #(.LIMIT(HZ_CYC - 1), .SAT_RST(1'b1)) u_hz_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (st == ST_ACC),
    .done  (hz_ok)
  );

  prom_lane_pick #(.DW(DW)) u_pick (
    .byte_mode (mode_q),
    .lanes     (rom_d_in),
    .value     (picked)
  );

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;
  // the ROM may still drive the top lane only after a word read
  assign need_turn = req_byte && !prev_byte && !hz_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      addr_q    <= '0;
      mode_q    <= 1'b0;
      prev_byte <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            addr_q <= req_addr;
            mode_q <= req_byte;
            st     <= need_turn ? ST_TURN : ST_ACC;
          end
        end
        ST_TURN: begin
          if (hz_ok) st <= ST_ACC;
        end
        ST_ACC: begin
          if (acc_done) begin
            st        <= ST_IDLE;
            rsp_valid <= 1'b1;
            rsp_data  <= picked;
            prev_byte <= mode_q;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign rom_ce_n    = (st != ST_ACC);
  assign rom_oe_n    = (st != ST_ACC);
  assign rom_byte_n  = !mode_q;
  assign rom_addr    = mode_q ? addr_q[BW-1:1] : addr_q[WA-1:0];
  assign rom_d15_out = mode_q & addr_q[0];
  assign rom_d15_oe  = (st == ST_ACC) && mode_q;
endmodule

// File: rtl/prom_rd_chk.sv
module prom_rd_chk #(
  parameter int WA      = 23,
  parameter int ACC_CYC = 10,
  parameter int HZ_CYC  = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rom_ce_n,
  input logic          rom_oe_n,
  input logic          rom_byte_n,
  input logic [WA-1:0] rom_addr,
  input logic          rom_d15_out,
  input logic          rom_d15_oe
);
  localparam int LW = $clog2(ACC_CYC + 2);
  localparam int IW = $clog2(HZ_CYC + 2);

  logic [LW-1:0] low_cnt;
  logic [IW-1:0] idle_cnt;
  logic          last_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt   <= '0;
      idle_cnt  <= '0;
      last_word <= 1'b0;
    end else begin
      if (!rom_ce_n) begin
        if (low_cnt != {LW{1'b1}}) low_cnt <= low_cnt + 1'b1;
      end else begin
        low_cnt <= '0;
      end
      if (!rom_oe_n) idle_cnt <= '0;
      else if (idle_cnt != {IW{1'b1}}) idle_cnt <= idle_cnt + 1'b1;
      if (!rom_ce_n) last_word <= rom_byte_n;
    end
  end

  a_r2_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (rom_ce_n && rom_oe_n));

  a_r5_window_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rom_ce_n) |-> (low_cnt == LW'(ACC_CYC)));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r6_after_window: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rom_ce_n && $past(!rom_ce_n)));

  a_r7_lane_drive: assert property (@(posedge clk) disable iff (!rst_n)
    rom_d15_oe |-> (!rom_ce_n && !rom_oe_n && !rom_byte_n));

  a_r8_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rom_d15_oe) && last_word) |-> (idle_cnt >= IW'(HZ_CYC)));

  a_r10_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_ce_n && $past(!rom_ce_n)) |->
      ($stable(rom_addr) && $stable(rom_byte_n) && $stable(rom_d15_out)));
endmodule

bind prom_rd_ctrl prom_rd_chk #(
  .WA      (WA),
  .ACC_CYC (ACC_CYC),
  .HZ_CYC  (HZ_CYC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .rom_ce_n    (rom_ce_n),
  .rom_oe_n    (rom_oe_n),
  .rom_byte_n  (rom_byte_n),
  .rom_addr    (rom_addr),
  .rom_d15_out (rom_d15_out),
  .rom_d15_oe  (rom_d15_oe)
);

// File: tb/prom_rd_ctrl_bench.sv
module prom_rd_ctrl_bench;
  localparam int AA  = 10;  // 100 ns at 10 ns clock
  localparam int OE  = 3;   // 30 ns rounded up
  localparam int HZ  = 2;   // 20 ns
  localparam int ACC = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [23:0] req_addr;
  logic        req_byte;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        rom_ce_n, rom_oe_n, rom_byte_n;
  logic [22:0] rom_addr;
  logic [15:0] rom_d_in;
  logic        rom_d15_out, rom_d15_oe;

  always #5 clk = ~clk;

  prom_rd_ctrl u_prom_rd_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_byte(req_byte),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n), .rom_byte_n(rom_byte_n),
    .rom_addr(rom_addr), .rom_d_in(rom_d_in),
    .rom_d15_out(rom_d15_out), .rom_d15_oe(rom_d15_oe)
  );

  int  n_chk = 0;
  int  n_fail = 0;
  bit  finished = 0;

  // ---------------- behavioural ROM ----------------
  function automatic logic [15:0] rom_word(input logic [22:0] a);
    return {a[7:0], a[15:8]} ^ {9'h0, a[22:16]} ^ 16'h3C5A;
  endfunction

  int ce_age = 0, oe_age = 0, ad_age = 0;
  logic [24:0] key_prev = '0;

  always @(posedge clk) begin
    ce_age   <= rom_ce_n ? 0 : ce_age + 1;
    oe_age   <= rom_oe_n ? 0 : oe_age + 1;
    ad_age   <= ({rom_addr, rom_byte_n, rom_d15_out} == key_prev) ? ad_age + 1 : 1;
    key_prev <= {rom_addr, rom_byte_n, rom_d15_out};
  end

  always_comb begin
    logic [15:0] w;
    w = rom_word(rom_addr);
    if (rom_ce_n || rom_oe_n || (ce_age + 1 < AA) || (ad_age + 1 < AA) || (oe_age + 1 < OE))
      rom_d_in = 'x;
    else if (rom_byte_n)
      rom_d_in = w;
    else if (!rom_d15_oe)
      rom_d_in = 'x;
    else
      rom_d_in = {8'hxx, rom_d15_out ? w[15:8] : w[7:0]};
  end

  // ---------------- bus monitor ----------------
  int          run = 0, last_run = 0, idle = 0, gap = 0, d15_cnt = 0;
  int          rsp_run = 0, rsp_long = 0, rsp_cnt = 0;
  logic [22:0] acc_addr;
  logic        acc_byte_n, acc_d15v;

  always @(posedge clk) begin
    if (rst_n) begin
      if (!rom_ce_n) begin
        if (run == 0) begin gap = idle; d15_cnt = 0; end
        run++;
        acc_addr = rom_addr; acc_byte_n = rom_byte_n; acc_d15v = rom_d15_out;
        if (rom_d15_oe) d15_cnt++;
        idle = 0;
      end else begin
        if (run != 0) last_run = run;
        run = 0;
        idle++;
      end
      if (rsp_valid) begin rsp_cnt++; rsp_run++; if (rsp_run > 1) rsp_long++; end
      else rsp_run = 0;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // called at a negedge; returns at the negedge where rsp_valid is seen
  task automatic run_req(input logic [23:0] a, input logic b, output int lat, output logic [15:0] d);
    req_addr = a; req_byte = b; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 100) begin @(negedge clk); lat++; end
    d = rsp_data;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_byte = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ce_n idle", rom_ce_n, 1);
    chk("R1 oe_n idle", rom_oe_n, 1);
    chk("R1 lane drive idle", rom_d15_oe, 0);
    chk("R1 ready idle", req_ready, 1);
    chk("R1 rsp_valid idle", rsp_valid, 0);
  endtask

  task automatic t_word(input logic [23:0] a);
    int lat; logic [15:0] d;
    run_req(a, 1'b0, lat, d);
    chk("R3 word data", d, rom_word(a[22:0]));
    chk("R6 word latency", lat, ACC + 1);
    @(negedge clk);
    chk("R5 enable window", last_run, ACC);
    chk("R3 word address", acc_addr, a[22:0]);
    chk("R3 width select", acc_byte_n, 1);
    chk("R7 no drive in word", d15_cnt, 0);
    chk("R6 one pulse", rsp_long, 0);
    chk("R1 back to idle", {rom_ce_n, rom_oe_n, req_ready}, 3'b111);
  endtask

  task automatic t_byte(input logic [23:0] a);
    int lat; logic [15:0] d; logic [15:0] w;
    w = rom_word(a[23:1]);
    run_req(a, 1'b1, lat, d);
    chk("R4 byte data", d, {8'h00, a[0] ? w[15:8] : w[7:0]});
    @(negedge clk);
    chk("R4 byte address", acc_addr, a[23:1]);
    chk("R4 low address bit", acc_d15v, a[0]);
    chk("R4 width select", acc_byte_n, 0);
    chk("R7 drive whole access", d15_cnt, ACC);
  endtask

  task automatic t_turn();
    int lat; logic [15:0] d; logic [15:0] w;
    run_req(24'h012345, 1'b0, lat, d);
    chk("R3 word before switch", d, rom_word(23'h012345));
    // next request offered in the response cycle itself
    w = rom_word(23'h2AB3C4 >> 0);
    run_req({23'h2AB3C4, 1'b1}, 1'b1, lat, d);
    chk("R8 byte after word data", d, {8'h00, w[15:8]});
    chk("R8 latency with wait", lat, ACC + 2);
    @(negedge clk);
    chk("R8 idle cycles before drive", gap, HZ);
    chk("R7 drive after wait", d15_cnt, ACC);
  endtask

  task automatic t_nowait();
    int lat; logic [15:0] d; logic [15:0] w;
    run_req(24'h000011, 1'b1, lat, d);
    w = rom_word(23'h000021);
    run_req(24'h000042, 1'b1, lat, d);
    chk("R9 byte after byte data", d, {8'h00, w[7:0]});
    chk("R9 latency no wait", lat, ACC + 1);
    @(negedge clk);
    chk("R9 one idle cycle", gap, 1);
    w = rom_word(23'h000777);
    run_req(24'h000777, 1'b0, lat, d);
    chk("R9 word after byte latency", lat, ACC + 1);
    chk("R9 word after byte data", d, w);
  endtask

  task automatic t_busy();
    int base; int busy_ready = 0; int n = 0;
    @(negedge clk);
    base = rsp_cnt;
    req_addr = 24'h00BEEF; req_byte = 1'b0; req_valid = 1'b1;
    @(negedge clk);  // taken at the edge before
    while (!rsp_valid && n < 100) begin
      if (req_ready) busy_ready++;
      @(negedge clk); n++;
    end
    chk("R2 ready low during access", busy_ready, 0);
    chk("R2 held request data", rsp_data, rom_word(23'h00BEEF));
    @(negedge clk);  // second take happened at the edge before
    req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 100) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
    chk("R2 two responses for two windows", rsp_cnt - base, 2);
    chk("R6 pulses single cycle", rsp_long, 0);
  endtask

  initial begin
    t_reset();
    t_word(24'h5A1234);
    t_word(24'hDA1234);   // bit 23 has no effect in word mode
    t_byte(24'hABCDE2);
    t_byte(24'hABCDE3);
    t_turn();
    t_nowait();
    t_busy();
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end
endmodule